// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave with Write-Cycle Lockout

This block is the bus-facing half of a serial EEPROM, modelled in a fast system clock domain. Both bus lines are synchronised and deglitched, so pulses shorter than a parameterised number of system clocks are discarded. START and STOP conditions are recovered from the clean lines. A state machine then walks through device-address matching, two pointer bytes, and data bytes in either direction. Storage is a parameterised byte array behind a 15-bit byte pointer. When the array is smaller than 32768 bytes, the upper pointer bits alias onto it.

A STOP that closes a write transaction starts a timed internal write cycle, but only if at least one byte was committed in that transaction. While the cycle runs, the slave leaves SDA released and does not react to START, STOP or its own address, so the bus master sees a NACK. A write-protect input keeps the array from changing. Protected data bytes are still acknowledged, but they are not stored and they do not start a write cycle.

States: `ST_IDLE` (unaddressed), `ST_DEV` / `ST_DEV_ACK` (device byte and its acknowledge), `ST_AHI` / `ST_AHI_ACK` and `ST_ALO` / `ST_ALO_ACK` (pointer high and low bytes), `ST_WDAT` / `ST_WDAT_ACK` (write data), `ST_RDAT` / `ST_RDAT_ACK` (read data and the master's acknowledge), and `ST_BUSY` (write cycle).

Transitions:
- Any state except `ST_BUSY` goes to `ST_DEV` on START.
- On STOP, any state except `ST_BUSY` goes to `ST_BUSY` if a byte is pending, and to `ST_IDLE` otherwise.
- `ST_DEV` goes to `ST_DEV_ACK` on an address match and to `ST_IDLE` on a mismatch.
- `ST_DEV_ACK` goes to `ST_AHI` for a write and to `ST_RDAT` for a read.
- `ST_AHI` → `ST_AHI_ACK` → `ST_ALO` → `ST_ALO_ACK` → `ST_WDAT` ⇄ `ST_WDAT_ACK`.
- `ST_RDAT` → `ST_RDAT_ACK`. From there the machine returns to `ST_RDAT` if the master acknowledged, and goes to `ST_IDLE` if it did not.
- `ST_BUSY` goes to `ST_IDLE` when the write timer expires.

Top module: `eeprom_2w_slave`

## Requirements
- R1: After reset the slave is in `ST_IDLE` with SDA released (`sda_oe_o` = 0).
- R2: A device byte is accepted only when its upper seven bits equal 4'b1010 followed by `strap_i[2:0]`. Bit 0 selects read (1) or write (0). On a match, SDA is pulled low for the ninth clock. On a mismatch there is no acknowledge, and the bus is ignored until the next START.
- R3: After a write device byte, two pointer bytes load the byte pointer, high byte first. Only the low 15 bits are used. Each later data byte is acknowledged, stored at the pointer, and the pointer then increments.
- R4: After a read device byte, bytes are sent MSB first from the pointer, and the pointer increments after each byte. Reading continues while the master acknowledges. After a NACK the slave releases SDA and goes idle.
- R5: A repeated START at any point outside the write cycle restarts the device-address phase. The pointer is kept.
- R6: A STOP after at least one committed byte starts a write cycle of `WR_CYC` system clocks. During that cycle SDA stays released, and START, STOP and the device address are ignored, so no acknowledge is given.
- R7: When the write cycle ends, the slave acknowledges its address again.
- R8: While `wp_i` is 1, data bytes are acknowledged but not stored, and a STOP after them starts no write cycle.
- R9: A pulse on SCL or SDA shorter than `FILT_CYC` system clocks has no effect on the transfer.
- R10: A STOP with no committed byte pending returns the slave to idle at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain); 0 releases it |
| strap_i | input | 3 | Device-select straps, compared with address bits 3..1 |
| wp_i | input | 1 | Write protect; 1 blocks array commits |

## Verification
The hardest situation to reach is the lockout window. The bench has to issue a new START inside the few thousand clocks after a committing STOP, and then confirm that the window ends on time. To do this, the bench addresses the slave immediately after a three-byte write and expects a NACK. It then waits past `WR_CYC` and expects an ACK. It also repeats the immediate address attempt after a protected write and after a dummy write, where no cycle may start. Glitch rejection is reached by inserting short pulses on SCL during a low phase and on SDA while SCL is high, partway through a data byte, and then reading that byte back.

// File: rtl/e2w_pkg.sv
package e2w_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_AHI,
        ST_AHI_ACK,
        ST_ALO,
        ST_ALO_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RDAT_ACK,
        ST_BUSY
    } e2w_state_t;

    localparam logic [3:0] DEV_TYPE = 4'b1010;

endpackage

// File: rtl/e2w_deglitch.sv
module e2w_deglitch #(
    parameter int STABLE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);
    localparam int CW = $clog2(STABLE_CYC + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;
    logic          clean_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q  <= 2'b11;
            cnt_q   <= '0;
            clean_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], raw_i};
            if (sync_q[1] == clean_q) begin
                cnt_q <= '0;
            end else if (cnt_q == CW'(STABLE_CYC - 1)) begin
                clean_q <= sync_q[1];
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    assign clean_o = clean_q;

    AST_FILT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (clean_q != $past(clean_q)) |-> ($past(sync_q[1], 1) == clean_q && $past(sync_q[1], 2) == clean_q)) // R9
        else $error("filtered line moved on a short pulse");

endmodule

// File: rtl/e2w_wrcycle.sv
module e2w_wrcycle #(
    parameter int CYC = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start_i) begin
            cnt_q <= CW'(CYC);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign busy_o = (cnt_q != '0);

    AST_WR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(CYC)) // R6
        else $error("write timer beyond its limit");

    AST_WR_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !start_i) |=> (cnt_q == $past(cnt_q) - CW'(1))) // R6
        else $error("write timer did not count down");

endmodule

// File: rtl/e2w_mem.sv
module e2w_mem #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] arr [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            arr[addr_i] <= wdata_i;
        end
    end

    assign rdata_o = arr[addr_i];

endmodule

// File: rtl/eeprom_2w_slave.sv
module eeprom_2w_slave
    import e2w_pkg::*;
#(
    parameter int ADDR_W   = 15,
    parameter int MEM_AW   = 8,
    parameter int FILT_CYC = 4,
    parameter int WR_CYC   = 2000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic [2:0] strap_i,
    input  logic       wp_i
);
    localparam int HI_W = ADDR_W - 8;

    // line conditioning: index 0 = SCL, index 1 = SDA
    logic [1:0] raw_w;
    logic [1:0] clean_w;
    assign raw_w = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_flt
        e2w_deglitch #(.STABLE_CYC(FILT_CYC)) u_flt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw_w[g]),
            .clean_o(clean_w[g])
        );
    end

    logic scl_f, sda_f, scl_q, sda_q;
    assign scl_f = clean_w[0];
    assign sda_f = clean_w[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    logic scl_rise, scl_fall, start_det, stop_det;
    assign scl_rise  = scl_f & ~scl_q;
    assign scl_fall  = ~scl_f & scl_q;
    assign start_det = scl_f & scl_q & sda_q & ~sda_f;
    assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;

    e2w_state_t        state_q;
    logic [3:0]        bit_q;
    logic [7:0]        sr_q;
    logic [7:0]        tx_q;
    logic [ADDR_W-1:0] ptr_q;
    logic              rw_q;
    logic              mack_q;
    logic              pend_q;

    logic       wr_busy, wr_go, mem_we;
    logic [7:0] rd_data;

    assign wr_go  = stop_det & pend_q & (state_q != ST_BUSY);
    assign mem_we = (state_q == ST_WDAT) & scl_fall & (bit_q == 4'd8) & ~wp_i;

    e2w_wrcycle #(.CYC(WR_CYC)) u_wrc (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(wr_go),
        .busy_o (wr_busy)
    );

    e2w_mem #(.AW(MEM_AW), .DW(8)) u_mem (
        .clk    (clk),
        .we_i   (mem_we),
        .addr_i (ptr_q[MEM_AW-1:0]),
        .wdata_i(sr_q),
        .rdata_o(rd_data)
    );

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
            sr_q    <= '0;
            tx_q    <= '0;
            ptr_q   <= '0;
            rw_q    <= 1'b0;
            mack_q  <= 1'b0;
            pend_q  <= 1'b0;
        end else if (state_q == ST_BUSY) begin
            if (!wr_busy) begin
                state_q <= ST_IDLE;
            end
        end else if (stop_det) begin
            state_q <= pend_q ? ST_BUSY : ST_IDLE;
            pend_q  <= 1'b0;
        end else if (start_det) begin
            state_q <= ST_DEV;
            bit_q   <= '0;
        end else begin
            unique case (state_q)
                ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
                    if (scl_rise) begin
                        sr_q  <= {sr_q[6:0], sda_f};
                        bit_q <= bit_q + 4'd1;
                    end else if (scl_fall && bit_q == 4'd8) begin
                        bit_q <= '0;
                        unique case (state_q)
                            ST_DEV: begin
                                if (sr_q[7:1] == {DEV_TYPE, strap_i}) begin
                                    rw_q    <= sr_q[0];
                                    state_q <= ST_DEV_ACK;
                                end else begin
                                    state_q <= ST_IDLE;
                                end
                            end
                            ST_AHI: begin
                                ptr_q[ADDR_W-1:8] <= sr_q[HI_W-1:0];
                                state_q <= ST_AHI_ACK;
                            end
                            ST_ALO: begin
                                ptr_q[7:0] <= sr_q;
                                state_q    <= ST_ALO_ACK;
                            end
                            default: begin
                                if (!wp_i) begin
                                    pend_q <= 1'b1;
                                end
                                ptr_q   <= ptr_q + ADDR_W'(1);
                                state_q <= ST_WDAT_ACK;
                            end
                        endcase
                    end
                end
                ST_DEV_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_WDAT_ACK: begin
                    if (scl_fall) begin
                        bit_q <= '0;
                        if (state_q == ST_DEV_ACK && rw_q) begin
                            tx_q    <= rd_data;
                            ptr_q   <= ptr_q + ADDR_W'(1);
                            state_q <= ST_RDAT;
                        end else if (state_q == ST_DEV_ACK) begin
                            state_q <= ST_AHI;
                        end else if (state_q == ST_AHI_ACK) begin
                            state_q <= ST_ALO;
                        end else begin
                            state_q <= ST_WDAT;
                        end
                    end
                end
                ST_RDAT: begin
                    if (scl_fall) begin
                        if (bit_q == 4'd7) begin
                            bit_q   <= '0;
                            state_q <= ST_RDAT_ACK;
                        end else begin
                            tx_q  <= {tx_q[6:0], 1'b0};
                            bit_q <= bit_q + 4'd1;
                        end
                    end
                end
                ST_RDAT_ACK: begin
                    if (scl_rise) begin
                        mack_q <= ~sda_f;
                    end else if (scl_fall) begin
                        if (mack_q) begin
                            tx_q    <= rd_data;
                            ptr_q   <= ptr_q + ADDR_W'(1);
                            state_q <= ST_RDAT;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_DEV_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_WDAT_ACK: sda_oe_o = 1'b1;
            ST_RDAT:                                         sda_oe_o = ~tx_q[7];
            default:                                         sda_oe_o = 1'b0;
        endcase
    end

    AST_BUSY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY) |=> (state_q == ST_BUSY || state_q == ST_IDLE)) // R6
        else $error("bus activity left the write cycle");

    AST_TIMER_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_busy |-> (state_q == ST_BUSY)) // R6
        else $error("write timer running outside busy state");

    AST_OE_SCOPE: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe_o |-> (state_q == ST_DEV_ACK || state_q == ST_AHI_ACK || state_q == ST_ALO_ACK ||
                      state_q == ST_WDAT_ACK || state_q == ST_RDAT)) // R2
        else $error("SDA driven outside an acknowledge or read slot");

    AST_IDLE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_BUSY && state_q == ST_IDLE) |-> !$past(wr_busy)) // R7
        else $error("left busy before the timer expired");

endmodule

// File: tb/tb_eeprom_2w_slave.sv
module tb_eeprom_2w_slave;
    localparam int CLK_NS = 10;
    localparam int TH     = 16;
    localparam int WRC    = 2000;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
    localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic wp = 1'b0;
    logic sda_oe;
    logic sda_line;

    assign sda_line = sda_m & ~sda_oe;

    always #(CLK_NS / 2) clk = ~clk;

    eeprom_2w_slave #(.ADDR_W(15), .MEM_AW(8), .FILT_CYC(4), .WR_CYC(WRC)) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_m),
        .sda_i   (sda_line),
        .sda_oe_o(sda_oe),
        .strap_i (STRAP),
        .wp_i    (wp)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [7:0] exp_v [$];
    string      exp_t [$];
    logic [7:0] obs_v;
    event       obs_ev;

    // scoreboard monitor
    initial forever begin
        @(obs_ev);
        n_cmp++;
        if (exp_v.size() == 0) begin
            n_bad++;
            $display("FAIL unexpected item: got %0h expected none", obs_v);
        end else begin
            logic [7:0] e;
            string t;
            e = exp_v.pop_front();
            t = exp_t.pop_front();
            if (obs_v !== e) begin
                n_bad++;
                $display("FAIL %s: got %0h expected %0h", t, obs_v, e);
            end
        end
    end

    task automatic push_exp(input logic [7:0] v, input string t);
        exp_v.push_back(v);
        exp_t.push_back(t);
    endtask

    task automatic report(input logic [7:0] v);
        obs_v = v;
        ->obs_ev;
    endtask

    task automatic hw(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; hw(TH);
        sda_m = 1'b0; hw(TH);
        scl_m = 1'b0;
    endtask

    task automatic bus_rstart();
        hw(TH / 2); sda_m = 1'b1; hw(TH / 2);
        scl_m = 1'b1; hw(TH);
        sda_m = 1'b0; hw(TH);
        scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        hw(TH / 2); sda_m = 1'b0; hw(TH / 2);
        scl_m = 1'b1; hw(TH);
        sda_m = 1'b1; hw(TH);
    endtask

    task automatic send_bit(input logic b);
        hw(TH / 2); sda_m = b; hw(TH / 2);
        scl_m = 1'b1; hw(TH);
        scl_m = 1'b0;
    endtask

    // bit with short pulses on both lines (rejected by the filter)
    task automatic send_bit_glitch(input logic b);
        hw(TH / 2); sda_m = b; hw(3);
        scl_m = 1'b1; hw(2); scl_m = 1'b0;
        hw(TH / 2 - 5);
        scl_m = 1'b1; hw(5);
        sda_m = ~b; hw(2); sda_m = b;
        hw(TH - 7);
        scl_m = 1'b0;
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; hw(TH);
        scl_m = 1'b1; hw(TH / 2);
        b = sda_line; hw(TH / 2);
        scl_m = 1'b0;
    endtask

    task automatic wr_byte(input logic [7:0] v, input logic exp_ack, input string t);
        logic a;
        push_exp({7'd0, exp_ack}, t);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(a);
        report({7'd0, ~a});
    endtask

    task automatic wr_byte_glitch(input logic [7:0] v, input string t);
        logic a;
        push_exp(8'd1, t);
        for (int i = 7; i >= 0; i--) begin
            if (v[i]) send_bit_glitch(v[i]);
            else send_bit(v[i]);
        end
        recv_bit(a);
        report({7'd0, ~a});
    endtask

    task automatic rd_byte(input logic [7:0] e, input logic give_ack, input string t);
        logic [7:0] v;
        push_exp(e, t);
        for (int i = 7; i >= 0; i--) begin
            logic b;
            recv_bit(b);
            v[i] = b;
        end
        send_bit(~give_ack);
        report(v);
    endtask

    task automatic set_ptr(input logic [14:0] a, input string t);
        wr_byte(DEV_W, 1'b1, t);
        wr_byte({1'b0, a[14:8]}, 1'b1, t);
        wr_byte(a[7:0], 1'b1, t);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog (all requirements): got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        hw(5);
        rst_n = 1'b1;
        hw(10);
        // R1: line released after reset
        push_exp(8'd1, "R1 reset release");
        report({7'd0, sda_line});
        hw(2);

        // R2: wrong strap and wrong type are not acknowledged
        bus_start();
        wr_byte({4'b1010, 3'b010, 1'b0}, 1'b0, "R2 strap mismatch");
        bus_stop();
        bus_start();
        wr_byte({4'b1011, STRAP, 1'b0}, 1'b0, "R2 type mismatch");
        bus_stop();

        // R3: three-byte write at 0x0010
        bus_start();
        set_ptr(15'h0010, "R3 pointer load");
        wr_byte(8'hA5, 1'b1, "R3 data ack");
        wr_byte(8'h3C, 1'b1, "R3 data ack");
        wr_byte(8'h81, 1'b1, "R3 data ack");
        bus_stop();

        // R6: address refused during write cycle
        bus_start();
        wr_byte(DEV_W, 1'b0, "R6 busy nack");
        bus_stop();
        hw(WRC + 100);

        // R7, R5, R4: ack after cycle, dummy write, repeated start, sequential read
        bus_start();
        set_ptr(15'h0010, "R7 ack after cycle");
        bus_rstart();
        wr_byte(DEV_R, 1'b1, "R5 repeated start read ack");
        rd_byte(8'hA5, 1'b1, "R4 read byte 0");
        rd_byte(8'h3C, 1'b1, "R4 read byte 1");
        rd_byte(8'h81, 1'b0, "R4 read byte 2");
        bus_stop();
        // R4: released after NACK
        push_exp(8'd1, "R4 release after nack");
        report({7'd0, sda_line});

        // R10: no commit pending, immediate response
        bus_start();
        wr_byte(DEV_W, 1'b1, "R10 no write cycle");
        bus_stop();

        // R8: protected write
        wp = 1'b1;
        bus_start();
        set_ptr(15'h0010, "R8 pointer load");
        wr_byte(8'hFF, 1'b1, "R8 protected data ack");
        bus_stop();
        bus_start();
        set_ptr(15'h0010, "R8 no write cycle");
        bus_rstart();
        wr_byte(DEV_R, 1'b1, "R8 read ack");
        rd_byte(8'hA5, 1'b0, "R8 content unchanged");
        bus_stop();
        wp = 1'b0;

        // R3: high pointer bits alias onto the array, R9: glitch during write
        bus_start();
        set_ptr(15'h0120, "R9 pointer load");
        wr_byte_glitch(8'h5A, "R9 glitched data ack");
        bus_stop();
        hw(WRC + 100);
        bus_start();
        set_ptr(15'h0020, "R9 pointer reload");
        bus_rstart();
        wr_byte(DEV_R, 1'b1, "R9 read ack");
        rd_byte(8'h5A, 1'b0, "R9 glitched byte intact");
        bus_stop();

        hw(10);
        if (exp_v.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard (all requirements): got %0d pending expected 0", exp_v.size());
        end
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule